// File: doc/BRIEF.md
# Coherence Issue Arbiter

This block is the front of a directory cache controller pipeline. Three kinds of message compete for entry into it each cycle: a line waiting in the eviction queue, a coherence response arriving from the network, and a coherence request arriving from the network. The block checks each one against the outcome of a transaction-table lookup, the state of the later pipeline stages, and the availability of the outbound networks. It then admits at most one per cycle.

Incoming requests pass through a small stall decoder. The decoder looks at the tracked line's transient state, the message type, and whether the sender is the line's recorded owner. It holds back messages that would disturb a transaction still in flight. The winning source is popped in the same cycle it is chosen. One cycle later the message, its class and its lookup result appear on registered outputs for the next stage.

The issue register is a four-state machine: `IS_IDLE`, `IS_RPL`, `IS_RSP` and `IS_REQ`. On every clock it moves to the state of the highest-priority eligible source, checked in the order replacement, response, request. If no source is eligible it moves to `IS_IDLE`. Reset forces `IS_IDLE`.

Top module: `dir_issue_arbiter`

## Requirements
- R1: While `rst_n` is low no source is popped, and `iss_valid` is low from reset until the first cycle after a grant.
- R2: A replacement is eligible only if `rq_empty` is low, `tbl_full` is low, the replacement lookup misses (`lk_hit[0]` low), both `s2_pending` and `s3_pending` are low, and both `fwd_net_avail` and `rsp_net_avail` are high.
- R3: A request is eligible only if `req_valid` is high, `tbl_full` is low, neither later stage is pending, and both networks are available.
- R4: A request also needs one of three conditions: its lookup misses; it hits an entry whose valid bit is clear; or it hits a valid entry and the stall decoder does not stall it.
- R5: A response is eligible whenever `rsp_valid` is high. Table, stage and network flags are ignored for it.
- R6: Priority is replacement, then response, then request. At most one of `rq_pop`, `rsp_ready`, `req_ready` is high in a cycle, and a pop is asserted only for the source selected in that cycle.
- R7: The stall decoder uses these state codes: 0 N, 1 I, 2 S, 3 M, 4 shared-awaiting-data, 5 M-evicting, 6 S-evicting, 7 N-filling. It uses these type codes: 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 replacement, 5 data, 6 ack, 7 forward. In state 4, a message of type 0, 1 or 4 from the owner is stalled, and the other types from the owner are not.
- R8: In states 5, 6 and 7 every message from the owner is stalled. In stable states 0 to 3 nothing is stalled.
- R9: A message whose `req_src` differs from the entry owner is never stalled.
- R10: Each source's address is split for lookup: tag is address bits [31:12] and set is bits [11:6]. Source slot 0 is the replacement, 1 the response, 2 the request, in `lk_tag` and `lk_set`.
- R11: The cycle after a grant, `iss_valid` is 1. `iss_class` is 1 for a replacement, 2 for a response, 3 for a request. The address, type, source, hit, index and entry fields are those of the granted source in the grant cycle; a replacement carries type 4 and source 0. With no grant, `iss_valid` is 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_empty | input | 1 | Eviction queue holds nothing |
| rq_addr | input | 32 | Address at the head of the eviction queue |
| rq_pop | output | 1 | Removes the queue head |
| rsp_valid | input | 1 | Network response present |
| rsp_addr | input | 32 | Response address |
| rsp_type | input | 3 | Response message type |
| rsp_src | input | 4 | Response sender node |
| rsp_ready | output | 1 | Response accepted |
| req_valid | input | 1 | Network request present |
| req_addr | input | 32 | Request address |
| req_type | input | 3 | Request message type |
| req_src | input | 4 | Request sender node |
| req_ready | output | 1 | Request accepted |
| lk_tag | output | 60 | Lookup tags, 20 bits per source slot |
| lk_set | output | 18 | Lookup sets, 6 bits per source slot |
| lk_hit | input | 3 | Lookup hit per slot |
| lk_idx | input | 9 | Hit entry index per slot |
| lk_ent_valid | input | 3 | Hit entry valid bit per slot |
| lk_ent_state | input | 9 | Hit entry state per slot |
| lk_ent_owner | input | 12 | Hit entry owner per slot |
| lk_ent_sharers | input | 48 | Hit entry sharer mask per slot |
| tbl_full | input | 1 | Transaction table has no free entry |
| s2_pending | input | 1 | Second stage busy |
| s3_pending | input | 1 | Third stage busy |
| fwd_net_avail | input | 1 | Forwarded-request network can accept |
| rsp_net_avail | input | 1 | Response network can accept |
| iss_valid | output | 1 | Issued message present |
| iss_class | output | 2 | Issued class |
| iss_addr | output | 32 | Issued address |
| iss_type | output | 3 | Issued message type |
| iss_src | output | 4 | Issued sender |
| iss_hit | output | 1 | Issued lookup hit |
| iss_idx | output | 3 | Issued entry index |
| iss_ent_valid | output | 1 | Issued entry valid bit |
| iss_ent_state | output | 3 | Issued entry state |
| iss_ent_owner | output | 4 | Issued entry owner |
| iss_ent_sharers | output | 16 | Issued entry sharer mask |

## Verification
A cycle can contain both a replacement becoming eligible and a response arriving. It can also contain a response arriving while the stall decoder is deciding whether a request waits. Directed cycles raise all three sources together, then pairs of sources, with hit entries in stalling and non-stalling states. Constrained random cycles then mix every flag and state freely. Each cycle is judged by comparing the three pop signals against a bench model of eligibility and priority, and then comparing the registered class and payload one clock later.

// File: rtl/dia_pkg.sv
package dia_pkg;

    localparam int ST_W    = 3;
    localparam int MT_W    = 3;
    localparam int NUM_SRC = 3;
    localparam int SRC_RPL = 0;
    localparam int SRC_RSP = 1;
    localparam int SRC_REQ = 2;

    typedef enum logic [ST_W-1:0] {
        DS_N        = 3'd0,
        DS_I        = 3'd1,
        DS_S        = 3'd2,
        DS_M        = 3'd3,
        DS_SHR_WAIT = 3'd4,
        DS_M_EVICT  = 3'd5,
        DS_S_EVICT  = 3'd6,
        DS_N_FILL   = 3'd7
    } dir_state_e;

    typedef enum logic [MT_W-1:0] {
        MT_GETS = 3'd0,
        MT_GETM = 3'd1,
        MT_PUTS = 3'd2,
        MT_PUTM = 3'd3,
        MT_REPL = 3'd4,
        MT_DATA = 3'd5,
        MT_ACK  = 3'd6,
        MT_FWD  = 3'd7
    } msg_type_e;

    typedef enum logic [1:0] {
        IS_IDLE = 2'd0,
        IS_RPL  = 2'd1,
        IS_RSP  = 2'd2,
        IS_REQ  = 2'd3
    } issue_state_e;

endpackage

// File: rtl/dia_addr_split.sv
module dia_addr_split #(
    parameter int LINE_W  = 26,
    parameter int SET_W   = 6,
    parameter int NUM_SRC = 3,
    localparam int TAG_W  = LINE_W - SET_W
) (
    input  logic [NUM_SRC*LINE_W-1:0] line_addr,
    output logic [NUM_SRC*TAG_W-1:0]  tags,
    output logic [NUM_SRC*SET_W-1:0]  sets
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_split
        assign sets[s*SET_W +: SET_W] = line_addr[s*LINE_W +: SET_W];
        assign tags[s*TAG_W +: TAG_W] = line_addr[s*LINE_W + SET_W +: TAG_W];
    end

endmodule

// File: rtl/dia_stall_decoder.sv
module dia_stall_decoder
    import dia_pkg::*;
(
    input  logic [ST_W-1:0] line_state,
    input  logic [MT_W-1:0] msg_type,
    input  logic            from_owner,
    output logic            stall
);

    dir_state_e st;
    msg_type_e  mt;

    assign st = dir_state_e'(line_state);
    assign mt = msg_type_e'(msg_type);

    always_comb begin
        stall = 1'b0;
        unique case (st)
            DS_N, DS_I, DS_S, DS_M: begin
                stall = 1'b0;
            end
            DS_SHR_WAIT: begin
                stall = from_owner &&
                        (mt == MT_GETS || mt == MT_GETM || mt == MT_REPL);
            end
            DS_M_EVICT, DS_S_EVICT, DS_N_FILL: begin
                stall = from_owner;
            end
        endcase
    end

endmodule

// File: rtl/dia_eligibility.sv
module dia_eligibility (
    input  logic rq_empty,
    input  logic rsp_valid,
    input  logic req_valid,
    input  logic tbl_full,
    input  logic rpl_hit,
    input  logic req_hit,
    input  logic req_ent_valid,
    input  logic req_stall,
    input  logic s2_pending,
    input  logic s3_pending,
    input  logic fwd_net_avail,
    input  logic rsp_net_avail,
    output logic rpl_ok,
    output logic rsp_ok,
    output logic req_ok
);

    logic path_free;
    logic req_tbl_ok;

    assign path_free  = !s2_pending && !s3_pending && fwd_net_avail && rsp_net_avail;
    assign req_tbl_ok = !req_hit || !req_ent_valid || !req_stall;

    assign rpl_ok = !rq_empty && !tbl_full && !rpl_hit && path_free;
    assign rsp_ok = rsp_valid;
    assign req_ok = req_valid && !tbl_full && req_tbl_ok && path_free;

endmodule

// File: rtl/dir_issue_arbiter.sv
module dir_issue_arbiter
    import dia_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 6,
    parameter int SET_W   = 6,
    parameter int TBL_N   = 8,
    parameter int NODES   = 16,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = LINE_W - SET_W,
    localparam int IDX_W  = $clog2(TBL_N),
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rq_empty,
    input  logic [ADDR_W-1:0]         rq_addr,
    output logic                      rq_pop,
    input  logic                      rsp_valid,
    input  logic [ADDR_W-1:0]         rsp_addr,
    input  logic [MT_W-1:0]           rsp_type,
    input  logic [NODE_W-1:0]         rsp_src,
    output logic                      rsp_ready,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [MT_W-1:0]           req_type,
    input  logic [NODE_W-1:0]         req_src,
    output logic                      req_ready,
    output logic [NUM_SRC*TAG_W-1:0]  lk_tag,
    output logic [NUM_SRC*SET_W-1:0]  lk_set,
    input  logic [NUM_SRC-1:0]        lk_hit,
    input  logic [NUM_SRC*IDX_W-1:0]  lk_idx,
    input  logic [NUM_SRC-1:0]        lk_ent_valid,
    input  logic [NUM_SRC*ST_W-1:0]   lk_ent_state,
    input  logic [NUM_SRC*NODE_W-1:0] lk_ent_owner,
    input  logic [NUM_SRC*NODES-1:0]  lk_ent_sharers,
    input  logic                      tbl_full,
    input  logic                      s2_pending,
    input  logic                      s3_pending,
    input  logic                      fwd_net_avail,
    input  logic                      rsp_net_avail,
    output logic                      iss_valid,
    output logic [1:0]                iss_class,
    output logic [ADDR_W-1:0]         iss_addr,
    output logic [MT_W-1:0]           iss_type,
    output logic [NODE_W-1:0]         iss_src,
    output logic                      iss_hit,
    output logic [IDX_W-1:0]          iss_idx,
    output logic                      iss_ent_valid,
    output logic [ST_W-1:0]           iss_ent_state,
    output logic [NODE_W-1:0]         iss_ent_owner,
    output logic [NODES-1:0]          iss_ent_sharers
);

    // ---------------- per-source unpacking ----------------
    logic [ADDR_W-1:0] addr_a    [NUM_SRC];
    logic [IDX_W-1:0]  idx_a     [NUM_SRC];
    logic [ST_W-1:0]   state_a   [NUM_SRC];
    logic [NODE_W-1:0] owner_a   [NUM_SRC];
    logic [NODES-1:0]  sharers_a [NUM_SRC];
    logic [NUM_SRC*LINE_W-1:0] line_flat;

    assign addr_a[SRC_RPL] = rq_addr;
    assign addr_a[SRC_RSP] = rsp_addr;
    assign addr_a[SRC_REQ] = req_addr;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
        assign idx_a[s]     = lk_idx[s*IDX_W +: IDX_W];
        assign state_a[s]   = lk_ent_state[s*ST_W +: ST_W];
        assign owner_a[s]   = lk_ent_owner[s*NODE_W +: NODE_W];
        assign sharers_a[s] = lk_ent_sharers[s*NODES +: NODES];
        assign line_flat[s*LINE_W +: LINE_W] = addr_a[s][ADDR_W-1:OFF_W];
    end

    // ---------------- lookup address split ----------------
    dia_addr_split #(
        .LINE_W  (LINE_W),
        .SET_W   (SET_W),
        .NUM_SRC (NUM_SRC)
    ) u_split (
        .line_addr (line_flat),
        .tags      (lk_tag),
        .sets      (lk_set)
    );

    // ---------------- stall decode for requests ----------------
    logic req_from_owner;
    logic req_stall;

    assign req_from_owner = (req_src == owner_a[SRC_REQ]);

    dia_stall_decoder u_stall (
        .line_state (state_a[SRC_REQ]),
        .msg_type   (req_type),
        .from_owner (req_from_owner),
        .stall      (req_stall)
    );

    // ---------------- eligibility ----------------
    logic rpl_ok, rsp_ok, req_ok;

    dia_eligibility u_elig (
        .rq_empty      (rq_empty),
        .rsp_valid     (rsp_valid),
        .req_valid     (req_valid),
        .tbl_full      (tbl_full),
        .rpl_hit       (lk_hit[SRC_RPL]),
        .req_hit       (lk_hit[SRC_REQ]),
        .req_ent_valid (lk_ent_valid[SRC_REQ]),
        .req_stall     (req_stall),
        .s2_pending    (s2_pending),
        .s3_pending    (s3_pending),
        .fwd_net_avail (fwd_net_avail),
        .rsp_net_avail (rsp_net_avail),
        .rpl_ok        (rpl_ok),
        .rsp_ok        (rsp_ok),
        .req_ok        (req_ok)
    );

    // ---------------- issue state machine ----------------
    issue_state_e state_q, state_d;

    always_comb begin
        state_d = IS_IDLE;
        if (rst_n) begin
            if (rpl_ok)      state_d = IS_RPL;
            else if (rsp_ok) state_d = IS_RSP;
            else if (req_ok) state_d = IS_REQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IS_IDLE;
        else        state_q <= state_d;
    end

    assign rq_pop    = (state_d == IS_RPL);
    assign rsp_ready = (state_d == IS_RSP);
    assign req_ready = (state_d == IS_REQ);

    // ---------------- payload capture ----------------
    logic [ADDR_W-1:0] sel_addr;
    logic [MT_W-1:0]   sel_type;
    logic [NODE_W-1:0] sel_src;
    int unsigned       sel_slot;

    always_comb begin
        sel_slot = SRC_RPL;
        sel_type = MT_REPL;
        sel_src  = '0;
        unique case (state_d)
            IS_IDLE, IS_RPL: begin
                sel_slot = SRC_RPL;
                sel_type = MT_REPL;
                sel_src  = '0;
            end
            IS_RSP: begin
                sel_slot = SRC_RSP;
                sel_type = rsp_type;
                sel_src  = rsp_src;
            end
            IS_REQ: begin
                sel_slot = SRC_REQ;
                sel_type = req_type;
                sel_src  = req_src;
            end
        endcase
        sel_addr = addr_a[sel_slot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_addr        <= '0;
            iss_type        <= '0;
            iss_src         <= '0;
            iss_hit         <= 1'b0;
            iss_idx         <= '0;
            iss_ent_valid   <= 1'b0;
            iss_ent_state   <= '0;
            iss_ent_owner   <= '0;
            iss_ent_sharers <= '0;
        end else if (state_d != IS_IDLE) begin
            iss_addr        <= sel_addr;
            iss_type        <= sel_type;
            iss_src         <= sel_src;
            iss_hit         <= lk_hit[sel_slot];
            iss_idx         <= idx_a[sel_slot];
            iss_ent_valid   <= lk_ent_valid[sel_slot];
            iss_ent_state   <= state_a[sel_slot];
            iss_ent_owner   <= owner_a[sel_slot];
            iss_ent_sharers <= sharers_a[sel_slot];
        end
    end

    // ---------------- state-driven outputs ----------------
    always_comb begin
        iss_valid = 1'b0;
        iss_class = 2'd0;
        unique case (state_q)
            IS_IDLE: begin iss_valid = 1'b0; iss_class = 2'd0; end
            IS_RPL:  begin iss_valid = 1'b1; iss_class = 2'd1; end
            IS_RSP:  begin iss_valid = 1'b1; iss_class = 2'd2; end
            IS_REQ:  begin iss_valid = 1'b1; iss_class = 2'd3; end
        endcase
    end

    // ---------------- assertions ----------------
    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rq_pop, rsp_ready, req_ready}));

    // R2
    rpl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_pop |-> (!rq_empty && !tbl_full && !lk_hit[SRC_RPL] && !s2_pending &&
                    !s3_pending && fwd_net_avail && rsp_net_avail));

    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (req_valid && !tbl_full && !s2_pending && !s3_pending &&
                       fwd_net_avail && rsp_net_avail));

    // R5
    rsp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rq_pop) |-> rsp_ready);

    // R11
    iss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_pop || rsp_ready || req_ready) |=> iss_valid);

    // R11
    iss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_pop || rsp_ready || req_ready) |=> !iss_valid);

    // R11
    rsp_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> (iss_class == 2'd2 && iss_addr == $past(rsp_addr)));

    // R7
    shr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit[SRC_REQ] && lk_ent_valid[SRC_REQ] &&
         state_a[SRC_REQ] == DS_SHR_WAIT && req_from_owner &&
         req_type == MT_GETS) |-> !req_ready);

    // R9
    non_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_from_owner && !tbl_full && !s2_pending && !s3_pending &&
         fwd_net_avail && rsp_net_avail && !rq_pop && !rsp_valid) |-> req_ready);

endmodule

// File: tb/tb_dir_issue_arbiter.sv
`timescale 1ns/1ps
module tb_dir_issue_arbiter;

    localparam int AW = 32;
    localparam int NW = 4;
    localparam int NN = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          rq_empty, rsp_valid, req_valid;
    logic [AW-1:0] a_b [3];
    logic [2:0]    t_b [3];
    logic [NW-1:0] s_b [3];
    logic          hit_b [3];
    logic [IW-1:0] idx_b [3];
    logic          ev_b [3];
    logic [2:0]    st_b [3];
    logic [NW-1:0] own_b [3];
    logic [NN-1:0] shr_b [3];
    logic          tbl_full, s2_pending, s3_pending, fwd_net_avail, rsp_net_avail;

    logic          rq_pop, rsp_ready, req_ready;
    logic [59:0]   lk_tag;
    logic [17:0]   lk_set;
    logic          iss_valid, iss_hit, iss_ent_valid;
    logic [1:0]    iss_class;
    logic [AW-1:0] iss_addr;
    logic [2:0]    iss_type, iss_ent_state;
    logic [NW-1:0] iss_src, iss_ent_owner;
    logic [IW-1:0] iss_idx;
    logic [NN-1:0] iss_ent_sharers;

    dir_issue_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .rq_empty(rq_empty), .rq_addr(a_b[0]), .rq_pop(rq_pop),
        .rsp_valid(rsp_valid), .rsp_addr(a_b[1]), .rsp_type(t_b[1]), .rsp_src(s_b[1]),
        .rsp_ready(rsp_ready),
        .req_valid(req_valid), .req_addr(a_b[2]), .req_type(t_b[2]), .req_src(s_b[2]),
        .req_ready(req_ready),
        .lk_tag(lk_tag), .lk_set(lk_set),
        .lk_hit({hit_b[2], hit_b[1], hit_b[0]}),
        .lk_idx({idx_b[2], idx_b[1], idx_b[0]}),
        .lk_ent_valid({ev_b[2], ev_b[1], ev_b[0]}),
        .lk_ent_state({st_b[2], st_b[1], st_b[0]}),
        .lk_ent_owner({own_b[2], own_b[1], own_b[0]}),
        .lk_ent_sharers({shr_b[2], shr_b[1], shr_b[0]}),
        .tbl_full(tbl_full), .s2_pending(s2_pending), .s3_pending(s3_pending),
        .fwd_net_avail(fwd_net_avail), .rsp_net_avail(rsp_net_avail),
        .iss_valid(iss_valid), .iss_class(iss_class), .iss_addr(iss_addr),
        .iss_type(iss_type), .iss_src(iss_src), .iss_hit(iss_hit), .iss_idx(iss_idx),
        .iss_ent_valid(iss_ent_valid), .iss_ent_state(iss_ent_state),
        .iss_ent_owner(iss_ent_owner), .iss_ent_sharers(iss_ent_sharers)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // R7 R8 R9 reference stall rule
    function automatic bit ref_stall(input logic [2:0] st, input logic [2:0] ty, input bit own);
        if (!own)    return 1'b0;
        if (st < 4)  return 1'b0;
        if (st == 4) return (ty == 3'd0 || ty == 3'd1 || ty == 3'd4);
        return 1'b1;
    endfunction

    // returns 0 none, 1 replacement, 2 response, 3 request
    function automatic int exp_grant();
        bit path, rpl, req;
        if (!rst_n) return 0;
        path = !s2_pending && !s3_pending && fwd_net_avail && rsp_net_avail;
        rpl  = !rq_empty && !tbl_full && !hit_b[0] && path;
        req  = req_valid && !tbl_full && path &&
               (!hit_b[2] || !ev_b[2] || !ref_stall(st_b[2], t_b[2], s_b[2] == own_b[2]));
        if (rpl)       return 1;
        if (rsp_valid) return 2;
        if (req)       return 3;
        return 0;
    endfunction

    function automatic logic [127:0] exp_vec(input int g);
        int s = g - 1;
        logic [2:0]    ty = (g == 1) ? 3'd4 : t_b[s];
        logic [NW-1:0] sr = (g == 1) ? '0 : s_b[s];
        return {59'd0, 2'(g), a_b[s], ty, sr, hit_b[s], idx_b[s], ev_b[s],
                st_b[s], own_b[s], shr_b[s]};
    endfunction

    task automatic run_cycle(input string rq);
        int g;
        logic [127:0] ev;
        logic [2:0] ep;
        logic [59:0] et;
        logic [17:0] es;
        #1;
        g  = exp_grant();
        ep = (g == 0) ? 3'b000 : (g == 1) ? 3'b001 : (g == 2) ? 3'b010 : 3'b100;
        chk({req_ready, rsp_ready, rq_pop} == ep, rq, "pops",
            {req_ready, rsp_ready, rq_pop}, ep);
        for (int s = 0; s < 3; s++) begin
            et[s*20 +: 20] = a_b[s][31:12];
            es[s*6 +: 6]   = a_b[s][11:6];
        end
        chk(lk_tag == et && lk_set == es, "R10", "split", {lk_tag, lk_set}, {et, es});
        if (g != 0) ev = exp_vec(g);
        else        ev = '0;
        @(posedge clk);
        #1;
        chk(iss_valid == (g != 0), {rq, " R11"}, "iss_valid", iss_valid, (g != 0));
        if (g != 0)
            chk({59'd0, iss_class, iss_addr, iss_type, iss_src, iss_hit, iss_idx,
                 iss_ent_valid, iss_ent_state, iss_ent_owner, iss_ent_sharers} == ev,
                {rq, " R11"}, "payload",
                {59'd0, iss_class, iss_addr, iss_type, iss_src, iss_hit, iss_idx,
                 iss_ent_valid, iss_ent_state, iss_ent_owner, iss_ent_sharers}, ev);
        @(negedge clk);
    endtask

    task automatic quiet();
        rq_empty = 1'b1; rsp_valid = 1'b0; req_valid = 1'b0;
        tbl_full = 1'b0; s2_pending = 1'b0; s3_pending = 1'b0;
        fwd_net_avail = 1'b1; rsp_net_avail = 1'b1;
        for (int s = 0; s < 3; s++) begin
            a_b[s] = $urandom; t_b[s] = 3'($urandom); s_b[s] = 4'($urandom);
            hit_b[s] = 1'b0; idx_b[s] = 3'($urandom); ev_b[s] = 1'b1;
            st_b[s] = 3'd0; own_b[s] = 4'($urandom); shr_b[s] = 16'($urandom);
        end
    endtask

    task automatic set_req(input logic [2:0] st, input logic [2:0] ty, input bit owner);
        req_valid = 1'b1; hit_b[2] = 1'b1; ev_b[2] = 1'b1;
        st_b[2] = st; t_b[2] = ty;
        own_b[2] = 4'd5;
        s_b[2] = owner ? 4'd5 : 4'd9;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        quiet();
        rq_empty = 1'b0; rsp_valid = 1'b1; req_valid = 1'b1;
        // R1: reset holds everything off
        run_cycle("R1");
        run_cycle("R1");
        rst_n = 1'b1;

        // R6: all three eligible, replacement wins
        quiet(); rq_empty = 1'b0; rsp_valid = 1'b1; req_valid = 1'b1;
        run_cycle("R6");
        // R6: response beats request
        quiet(); rsp_valid = 1'b1; req_valid = 1'b1;
        run_cycle("R6");
        // R3: stage busy or network down blocks request
        quiet(); req_valid = 1'b1; s2_pending = 1'b1;
        run_cycle("R3");
        quiet(); req_valid = 1'b1; fwd_net_avail = 1'b0;
        run_cycle("R3");
        quiet(); req_valid = 1'b1; tbl_full = 1'b1;
        run_cycle("R3");
        // R2: replacement hitting the table is held; response taken
        quiet(); rq_empty = 1'b0; hit_b[0] = 1'b1; rsp_valid = 1'b1;
        run_cycle("R2");
        quiet(); rq_empty = 1'b0; s3_pending = 1'b1;
        run_cycle("R2");
        // R5: response ignores every gating flag
        quiet(); rsp_valid = 1'b1; tbl_full = 1'b1; s2_pending = 1'b1;
        fwd_net_avail = 1'b0; rsp_net_avail = 1'b0;
        run_cycle("R5");
        // R7
        quiet(); set_req(3'd4, 3'd0, 1'b1); run_cycle("R7");
        quiet(); set_req(3'd4, 3'd1, 1'b1); run_cycle("R7");
        quiet(); set_req(3'd4, 3'd4, 1'b1); run_cycle("R7");
        quiet(); set_req(3'd4, 3'd2, 1'b1); run_cycle("R7");
        // R9
        quiet(); set_req(3'd4, 3'd1, 1'b0); run_cycle("R9");
        quiet(); set_req(3'd5, 3'd3, 1'b0); run_cycle("R9");
        // R8
        quiet(); set_req(3'd5, 3'd3, 1'b1); run_cycle("R8");
        quiet(); set_req(3'd7, 3'd2, 1'b1); run_cycle("R8");
        quiet(); set_req(3'd3, 3'd1, 1'b1); run_cycle("R8");
        // R4: hit on invalid entry is admitted despite stalling state
        quiet(); set_req(3'd4, 3'd0, 1'b1); ev_b[2] = 1'b0; run_cycle("R4");
        quiet(); set_req(3'd6, 3'd0, 1'b1); hit_b[2] = 1'b0; run_cycle("R4");

        // random mix
        for (int n = 0; n < 600; n++) begin
            quiet();
            rq_empty      = ($urandom % 3) == 0;
            rsp_valid     = ($urandom % 3) == 0;
            req_valid     = ($urandom % 4) != 0;
            tbl_full      = ($urandom % 7) == 0;
            s2_pending    = ($urandom % 7) == 0;
            s3_pending    = ($urandom % 7) == 0;
            fwd_net_avail = ($urandom % 8) != 0;
            rsp_net_avail = ($urandom % 8) != 0;
            for (int s = 0; s < 3; s++) begin
                hit_b[s] = $urandom % 2;
                ev_b[s]  = ($urandom % 4) != 0;
                st_b[s]  = 3'($urandom);
            end
            if ($urandom % 2) s_b[2] = own_b[2];
            run_cycle("R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule